// File: doc/BRIEF.md
# Dual-Mode Edge-Placed PWM Generator

This block drives six pulse-width outputs from one shared up-counter. Match register 0 holds the rate: the counter runs 0, 1, …, rate and then wraps to 0, so a PWM period lasts rate + 1 clocks. Each output is either single-edge or double-edge. A single-edge output rises at the start of every period and falls at its match value. A double-edge output is set by one match value and cleared by another. This allows a pulse to be placed anywhere in the period.

Software writes match values into shadow registers through a simple write port. A write to a shadow register only reaches the active register at a period boundary, and only when that register's latch-enable bit is set. The latch-enable bit clears itself once the load has happened. Mode bits take effect at once. While the global enable is low, the counter sits at 0, every output is low, and pending latched values load on every clock. A configuration written before enabling is therefore in force from the first period.

Double-edge channels follow a fixed set of tie-break rules at the boundary. A match of 0 acts like a match equal to the rate. An old rate-valued match may fire once more during an update. Clear beats set. Values above the rate never match.

Top module: `edgepwm_core`

## Requirements
- R1: The counter counts 0 to rate and wraps, so every output pattern repeats every rate + 1 clocks.
- R2: After reset, and one clock after enable goes low, all outputs are low. While disabled, the counter is held at 0.
- R3: A single-edge channel with match m, where 0 < m < rate, is high for m + 1 clocks per period. With m ≥ rate it stays high for the whole period.
- R4: A single-edge channel with match 0 stays low.
- R5: Double-edge channel n is set by match n−1 and cleared by match n. With both values strictly between 0 and rate, and s < k, the output is high for k − s clocks per period. With s > k it is high for rate + 1 − (s − k) clocks. A clear at the rate gives rate − s clocks high.
- R6: In double-edge mode a match of 0 behaves exactly like a match equal to the rate: the edge lands on the period boundary.
- R7: When set and clear land on the same instant, the output is cleared. This covers equal values, and also one value of 0 with the other equal to the rate.
- R8: A double-edge match greater than the rate never fires. A lone set then holds the output high, and a lone clear or no edge at all holds it low.
- R9: Register map on the write port: addresses 0..6 are match registers 0..6. Address 7 holds the mode bits; bit i selects double-edge (1) or single-edge (0) for output i+1. Address 8 sets latch-enable bits; bit j of the written data sets the bit for match register j.
- R10: A match write loads into the active register only at a boundary, or while disabled, and only when its latch-enable bit is set. Without the bit the write has no effect. The bit clears once the load is done.
- R11: At a boundary where double-edge values change, an old value equal to the old rate fires once more. This happens when neither new value is 0 or the new rate, and neither old value was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (see R9) |
| wr_data | input | 16 | Register write data |
| enable | input | 1 | Global run enable |
| pwm_out | output | 6 | PWM outputs, bit i is output i+1 |

## Verification
Every output is registered once past the counter compare. An edge requested at count c therefore shows up while the counter reads c + 1, and the boundary edge shows up at count 0. Written registers change on the clock after the strobe, and latched matches change only at the following boundary. The bench drives and samples on the falling clock. Before it measures duty, it lets at least two full periods pass after any enable or latch write, then counts high clocks over exactly rate + 1 samples, a count that does not depend on phase. The once-more rule is checked from an observed falling edge, which marks the first clock of a period. The latch bit is written inside the following low window, and the length of the next high run is measured.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;

  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_e;

endpackage

// File: rtl/edgepwm_regs.sv
module edgepwm_regs #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic                          load,
  output logic [NUM_CH:0][CNT_W-1:0]    act_q,
  output logic [NUM_CH:0][CNT_W-1:0]    nxt,
  output logic [NUM_CH-1:0]             mode_q
);

  localparam int NUM_M      = NUM_CH + 1;
  localparam int MODE_ADDR  = NUM_CH + 1;
  localparam int LATCH_ADDR = NUM_CH + 2;

  logic [NUM_CH:0][CNT_W-1:0] shadow_q, shadow_d, act_d;
  logic [NUM_M-1:0]           latch_q, latch_d;
  logic [NUM_CH-1:0]          mode_d;
  logic                       wr_mode, wr_latch;

  assign wr_mode  = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
  assign wr_latch = wr_en && (wr_addr == ADDR_W'(LATCH_ADDR));

  always_comb begin
    for (int i = 0; i < NUM_M; i++) begin
      shadow_d[i] = (wr_en && (wr_addr == ADDR_W'(i))) ? wr_data : shadow_q[i];
      nxt[i]      = latch_q[i] ? shadow_q[i] : act_q[i];
      act_d[i]    = load ? nxt[i] : act_q[i];
    end
    latch_d = load ? '0 : latch_q;
    if (wr_latch) begin
      latch_d = latch_d | wr_data[NUM_M-1:0];
    end
    mode_d = wr_mode ? wr_data[NUM_CH-1:0] : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      latch_q  <= '0;
      mode_q   <= '0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
      latch_q  <= latch_d;
      mode_q   <= mode_d;
    end
  end

  AST_LATCH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_latch) |=> (latch_q == '0)); // R10

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (act_q == $past(act_q))); // R10

endmodule

// File: rtl/edgepwm_counter.sv
module edgepwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] rate,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_d;

  assign wrap = en && (cnt_q >= rate);

  always_comb begin
    if (!en) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= rate)); // R1

  AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/edgepwm_chan.sv
module edgepwm_chan
  import edgepwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             boundary,
  input  edge_mode_e       mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rate_old,
  input  logic [CNT_W-1:0] rate_new,
  input  logic [CNT_W-1:0] set_old,
  input  logic [CNT_W-1:0] set_new,
  input  logic [CNT_W-1:0] clr_old,
  input  logic [CNT_W-1:0] clr_new,
  output logic             pwm_q
);

  logic pwm_d;
  logic set_new_b, clr_new_b, set_old_r, clr_old_r, old_zero, reuse;
  logic set_bnd, clr_bnd, set_hit, clr_hit;

  always_comb begin
    set_new_b = (set_new == '0) || (set_new == rate_new);
    clr_new_b = (clr_new == '0) || (clr_new == rate_new);
    set_old_r = (set_old == rate_old);
    clr_old_r = (clr_old == rate_old);
    old_zero  = (set_old == '0) || (clr_old == '0);
    reuse     = !set_new_b && !clr_new_b && !old_zero;
    set_bnd   = set_new_b || (reuse && set_old_r);
    clr_bnd   = clr_new_b || (reuse && clr_old_r);
    set_hit   = (set_old == cnt) && (set_old != '0);
    clr_hit   = (clr_old == cnt) && (clr_old != '0);
  end

  always_comb begin
    pwm_d = pwm_q;
    if (!en) begin
      pwm_d = 1'b0;
    end else if (mode == EDGE_SINGLE) begin
      if (boundary) begin
        pwm_d = (clr_new != '0);
      end else if (clr_hit) begin
        pwm_d = 1'b0;
      end
    end else begin
      if (boundary) begin
        if (clr_bnd) begin
          pwm_d = 1'b0;
        end else if (set_bnd) begin
          pwm_d = 1'b1;
        end
      end else begin
        if (clr_hit) begin
          pwm_d = 1'b0;
        end else if (set_hit) begin
          pwm_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  AST_SINGLE_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == EDGE_SINGLE && boundary && clr_new == '0) |=> !pwm_q); // R4

  AST_CLEAR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == EDGE_DOUBLE && !boundary && clr_old == cnt && clr_old != '0) |=> !pwm_q); // R7

  AST_OOR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !boundary && set_old > rate_old && clr_old > rate_old) |=> (pwm_q == $past(pwm_q))); // R8

endmodule

// File: rtl/edgepwm_core.sv
module edgepwm_core
  import edgepwm_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              enable,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [1:0]                 rst_sync_q;
  logic                       rst_n_s;
  logic [NUM_CH:0][CNT_W-1:0] act_q, nxt;
  logic [NUM_CH-1:0]          mode_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       wrap, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  assign load = wrap || !enable;

  edgepwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (load),
    .act_q   (act_q),
    .nxt     (nxt),
    .mode_q  (mode_q)
  );

  edgepwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (enable),
    .rate  (act_q[0]),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    edgepwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .en       (enable),
      .boundary (wrap),
      .mode     (edge_mode_e'(mode_q[g])),
      .cnt      (cnt_q),
      .rate_old (act_q[0]),
      .rate_new (nxt[0]),
      .set_old  (act_q[g]),
      .set_new  (nxt[g]),
      .clr_old  (act_q[g+1]),
      .clr_new  (nxt[g+1]),
      .pwm_q    (pwm_out[g])
    );
  end

  AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    !enable |=> (pwm_out == '0)); // R2

endmodule

// File: tb/edgepwm_core_test.sv
module edgepwm_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 6;
  localparam int CNT_W      = 16;
  localparam int ADDR_W     = 4;
  localparam int NVEC       = 4;

  // rate, mode bits, m1..m6, expected highs per period ch1..ch6
  localparam int TBL [NVEC][14] = '{
    '{9,  0,  0, 4, 9, 12, 1, 8,   0, 5, 10, 10, 2, 9},
    '{9,  42, 2, 6, 7, 3,  5, 5,   3, 4, 8,  6,  6, 0},
    '{11, 63, 0, 4, 11, 14, 13, 6, 0, 5, 7,  12, 0, 0},
    '{15, 7,  10, 3, 15, 20, 15, 0, 11, 9, 12, 16, 16, 0}
  };

  string tags [NVEC][NUM_CH] = '{
    '{"R4", "R3", "R3", "R3", "R3", "R3"},
    '{"R3", "R5", "R3", "R5", "R3", "R7"},
    '{"R7", "R6", "R6", "R8", "R8", "R8"},
    '{"R5", "R5", "R5", "R3", "R3", "R4"}
  };

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CNT_W-1:0]  wr_data;
  logic              enable;
  logic [NUM_CH-1:0] pwm_out;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  edgepwm_core #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .enable  (enable),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h [NUM_CH]);
    for (int c = 0; c < NUM_CH; c++) h[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) h[c] += int'(pwm_out[c]);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int h [NUM_CH];
    int n;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    enable  = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R2", "outputs after reset", int'(pwm_out), 0);

    // Table walk; R9: addr 0..6 match, 7 mode, 8 latch-enable bits
    for (int v = 0; v < NVEC; v++) begin
      int rate;
      rate = TBL[v][0];
      enable = 1'b0;
      wr(0, rate);
      for (int m = 1; m <= NUM_CH; m++) wr(m, TBL[v][1 + m]);
      wr(7, TBL[v][1]);
      wr(8, 'h7f);
      @(negedge clk);
      enable = 1'b1;
      idle(2 * (rate + 1) + 2);
      count_high(rate + 1, h);
      for (int c = 0; c < NUM_CH; c++)
        check(tags[v][c], $sformatf("vector %0d ch%0d highs (R9 map)", v, c + 1), h[c], TBL[v][8 + c]);
    end

    // R2: disable drops all outputs on the next clock
    enable = 1'b0;
    @(negedge clk);
    check("R2", "outputs after disable", int'(pwm_out), 0);

    // R1 period and R10 shadow/latch behaviour on single-edge ch2
    wr(0, 9);
    wr(2, 4);
    wr(7, 0);
    wr(8, 'h05);
    @(negedge clk);
    enable = 1'b1;
    idle(25);
    while (pwm_out[1] !== 1'b0) @(negedge clk);
    while (pwm_out[1] !== 1'b1) @(negedge clk);
    n = 0;
    @(negedge clk);
    n++;
    while (pwm_out[1] !== 1'b0) begin @(negedge clk); n++; end
    while (pwm_out[1] !== 1'b1) begin @(negedge clk); n++; end
    check("R1", "period between rises", n, 10);
    count_high(10, h);
    check("R3", "ch2 m=4 highs", h[1], 5);
    wr(2, 7);
    idle(25);
    count_high(10, h);
    check("R10", "unlatched write ignored", h[1], 5);
    wr(8, 'h04);
    idle(25);
    count_high(10, h);
    check("R10", "latched write applied", h[1], 8);
    wr(2, 2);
    idle(25);
    count_high(10, h);
    check("R10", "latch bit self-cleared", h[1], 8);

    // R11: old rate-valued clear fires once more
    enable = 1'b0;
    wr(0, 9);
    wr(1, 3);
    wr(2, 9);
    wr(7, 2);
    wr(8, 'h07);
    @(negedge clk);
    enable = 1'b1;
    idle(25);
    count_high(10, h);
    check("R5", "ch2 set=3 clear=rate highs", h[1], 6);
    wr(1, 2);
    wr(2, 5);
    while (pwm_out[1] !== 1'b1) @(negedge clk);
    while (pwm_out[1] !== 1'b0) @(negedge clk);
    wr(8, 'h06);
    while (pwm_out[1] !== 1'b1) @(negedge clk);
    n = 0;
    while (pwm_out[1] === 1'b1) begin @(negedge clk); n++; end
    check("R11", "high run across update boundary", n, 6);
    idle(20);
    count_high(10, h);
    check("R5", "ch2 set=2 clear=5 highs", h[1], 3);

    finish_run();
  end

endmodule